// File: doc/BRIEF.md
# Programmable Video Line Buffer

This block is the line-delay store that sits in front of a vertical image filter. Pixels arrive one per shift on an 8-bit port and pass through a chain of delay lines. Each line is as long as a length field set at run time, so each tap presents the pixel from the same column on an earlier scan line. A second, independent line buffer with its own input port can be switched on, so that odd and even fields can be filtered apart.

Each delay line is a circular RAM addressed by one shared pointer. The pointer wraps at the active length. Three loading schemes are selected by mode bits. In cascade loading each line feeds the next. In parallel loading every line takes the same input sample. In recirculation each line writes its oldest sample back to itself, so a stored line repeats forever. An active-low shift enable freezes the input registers, the pointer, the taps and the stored samples. After reset a small state machine first fills every RAM with zero (state CLEAR), then moves through the transition CLEAR_DONE into RUN, where it stays until the next reset.

Top module: `line_delay_bank`

## Requirements
- R1: While reset is asserted and during the clearing pass that follows it, `ready` is low and every tap, including `fld_tap`, reads zero. `ready` goes high exactly MAX_LEN clock edges after reset is released and then stays high.
- R2: With mode bits 0 and 1 both clear (cascade loading), tap k shows the pixel presented (k+1)*L+1 shifts earlier, where L is the active length. Tap 0 is in bits [7:0] of `taps`, tap 1 in bits [15:8], and so on.
- R3: With mode bit 0 set (recirculation), each line writes its oldest sample back in place of new data. This holds whatever the other mode bits are, and the taps repeat with period L while new pixels have no effect.
- R4: With mode bit 1 set and bit 0 clear (parallel loading), every line stores the same input sample, so all taps equal the pixel presented L+1 shifts earlier.
- R5: While `shift_n` is high in RUN, the taps, the stored samples, the pointer and the input registers do not change.
- R6: The length is the 12-bit field at address 0. A value of 0 acts as 1, and values above MAX_LEN act as MAX_LEN. A new length takes effect only at the next pointer wrap, or at the end of the clearing pass.
- R7: The mode register is at address 1: bit 0 selects recirculation, bit 1 parallel loading, bit 2 enables the field port, bit 3 enables the field buffer. `cfg_rdata` returns the selected register. Bits 11:4 of the mode register read as zero and ignore writes, and the length field reads back as written.
- R8: When mode bit 2 is clear, the field input register captures zero in place of `fld_in`.
- R9: When mode bit 3 is set, `fld_tap` shows the field sample captured L+1 shifts earlier. When bit 3 is clear, `fld_tap` reads zero.
- R10: Shifts requested while `ready` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_n | input | 1 | Shift enable, active low |
| pix_in | input | 8 | Pixel input |
| fld_in | input | 8 | Second field pixel input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Configuration register select (0 length, 1 mode) |
| cfg_wdata | input | 12 | Configuration write data |
| cfg_rdata | output | 12 | Read-back of the selected register |
| ready | output | 1 | High once the clearing pass has finished |
| taps | output | 24 | One 8-bit tap per delay line, line 0 in the low byte |
| fld_tap | output | 8 | Tap of the field line buffer |

## Verification
The hardest situation to reach is a length change that has been written but not yet applied. The pointer sits partway through a line under the old length, and the stored samples beyond the new length stay in RAM, so they reappear when the length later grows. The stimulus writes lengths of 0, then 100 (clamped), then 17. It does so while the pointer is mid-line, with hold cycles mixed in, and compares every tap against a behavioural model on every clock across each deferred switch. Shifts asserted during the clearing pass and field-buffer residue left over after a mode change are reached the same way.

// File: rtl/ldb_pkg.sv
package ldb_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } ldb_state_e;

    typedef struct packed {
        logic fld_buf_en;
        logic fld_port_en;
        logic par_load;
        logic recirc;
    } ldb_mode_t;

endpackage

// File: rtl/ldb_cfg.sv
module ldb_cfg
    import ldb_pkg::*;
#(
    parameter int CFG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             addr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] len_field,
    output ldb_mode_t        mode,
    output logic [CFG_W-1:0] rdata
);

    localparam int PAD_W = CFG_W - MODE_W;

    logic [CFG_W-1:0] len_q;
    ldb_mode_t        mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            mode_q <= '0;
        end else if (we) begin
            if (addr) begin
                mode_q <= ldb_mode_t'(wdata[MODE_W-1:0]);
            end else begin
                len_q <= wdata;
            end
        end
    end

    assign len_field = len_q;
    assign mode      = mode_q;
    assign rdata     = addr ? {{PAD_W{1'b0}}, mode_q} : len_q;

endmodule

// File: rtl/ldb_ctrl.sv
module ldb_ctrl
    import ldb_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int CFG_W   = 12,
    parameter int AW      = 6,
    parameter int LW      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_n,
    input  logic [CFG_W-1:0] len_field,
    output logic             ready,
    output logic             adv,
    output logic             clearing,
    output logic [AW-1:0]    ptr,
    output logic [LW-1:0]    len_act
);

    ldb_state_e    state_q;
    ldb_state_e    state_d;
    logic [AW-1:0] ptr_q;
    logic [LW-1:0] len_q;
    logic          last_clr;
    logic          at_wrap;

    function automatic logic [LW-1:0] clamp_len(input logic [CFG_W-1:0] v);
        if (v == '0) begin
            return LW'(1);
        end else if (v >= CFG_W'(MAX_LEN)) begin
            return LW'(MAX_LEN);
        end else begin
            return LW'(v);
        end
    endfunction

    assign last_clr = (ptr_q == AW'(MAX_LEN - 1));
    assign at_wrap  = (LW'(ptr_q) == (len_q - LW'(1)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: CLEAR_DONE moves CLEAR to RUN after the last address
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (last_clr) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        clearing = 1'b0;
        ready    = 1'b0;
        adv      = 1'b0;
        unique case (state_q)
            ST_CLEAR: clearing = 1'b1;
            ST_RUN: begin
                ready = 1'b1;
                adv   = ~shift_n;
            end
            default: clearing = 1'b1;
        endcase
    end

    // shared pointer and active length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            len_q <= LW'(1);
        end else if (clearing) begin
            if (last_clr) begin
                ptr_q <= '0;
                len_q <= clamp_len(len_field);
            end else begin
                ptr_q <= ptr_q + AW'(1);
            end
        end else if (adv) begin
            if (at_wrap) begin
                ptr_q <= '0;
                len_q <= clamp_len(len_field);
            end else begin
                ptr_q <= ptr_q + AW'(1);
            end
        end
    end

    assign ptr     = ptr_q;
    assign len_act = len_q;

endmodule

// File: rtl/ldb_line.sv
module ldb_line #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          adv,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] tap
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap <= '0;
        end else if (adv) begin
            tap <= rdata;
        end
    end

endmodule

// File: rtl/line_delay_bank.sv
module line_delay_bank
    import ldb_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int NUM_LINES = 3,
    parameter int MAX_LEN   = 64,
    parameter int CFG_W     = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_n,
    input  logic [PIX_W-1:0]           pix_in,
    input  logic [PIX_W-1:0]           fld_in,
    input  logic                       cfg_we,
    input  logic                       cfg_addr,
    input  logic [CFG_W-1:0]           cfg_wdata,
    output logic [CFG_W-1:0]           cfg_rdata,
    output logic                       ready,
    output logic [NUM_LINES*PIX_W-1:0] taps,
    output logic [PIX_W-1:0]           fld_tap
);

    localparam int AW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam int LW      = $clog2(MAX_LEN + 1);
    localparam int N_STORE = NUM_LINES + 1;

    logic [CFG_W-1:0] len_field;
    ldb_mode_t        mode_q;
    logic             adv;
    logic             clearing;
    logic [AW-1:0]    ptr_q;
    logic [LW-1:0]    len_act;
    logic [PIX_W-1:0] in_q;
    logic [PIX_W-1:0] fld_q;

    logic [PIX_W-1:0] rd_w  [N_STORE];
    logic [PIX_W-1:0] tap_w [N_STORE];
    logic [PIX_W-1:0] src_w [N_STORE];

    ldb_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .len_field (len_field),
        .mode      (mode_q),
        .rdata     (cfg_rdata)
    );

    ldb_ctrl #(
        .MAX_LEN (MAX_LEN),
        .CFG_W   (CFG_W),
        .AW      (AW),
        .LW      (LW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_n   (shift_n),
        .len_field (len_field),
        .ready     (ready),
        .adv       (adv),
        .clearing  (clearing),
        .ptr       (ptr_q),
        .len_act   (len_act)
    );

    // input and field capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= '0;
            fld_q <= '0;
        end else if (adv) begin
            in_q  <= pix_in;
            fld_q <= mode_q.fld_port_en ? fld_in : '0;
        end
    end

    for (genvar k = 0; k < N_STORE; k++) begin : g_line
        if (k == NUM_LINES) begin : g_src_fld
            assign src_w[k] = mode_q.recirc ? rd_w[k] : fld_q;
        end else if (k == 0) begin : g_src_first
            assign src_w[k] = mode_q.recirc ? rd_w[k] : in_q;
        end else begin : g_src_chain
            assign src_w[k] = mode_q.recirc   ? rd_w[k] :
                              mode_q.par_load ? in_q    : rd_w[k-1];
        end

        ldb_line #(
            .DW    (PIX_W),
            .DEPTH (MAX_LEN),
            .AW    (AW)
        ) u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (clearing | adv),
            .addr  (ptr_q),
            .wdata (clearing ? '0 : src_w[k]),
            .adv   (adv),
            .rdata (rd_w[k]),
            .tap   (tap_w[k])
        );

        if (k < NUM_LINES) begin : g_tap
            assign taps[k*PIX_W +: PIX_W] = tap_w[k];
        end
    end

    assign fld_tap = mode_q.fld_buf_en ? tap_w[NUM_LINES] : '0;

endmodule

// File: rtl/line_delay_bank_chk.sv
module line_delay_bank_chk #(
    parameter int PIX_W     = 8,
    parameter int NUM_LINES = 3,
    parameter int CFG_W     = 12,
    parameter int AW        = 6,
    parameter int LW        = 7
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       shift_n,
    input logic                       ready,
    input logic [NUM_LINES*PIX_W-1:0] taps,
    input logic [PIX_W-1:0]           fld_tap,
    input logic                       cfg_addr,
    input logic [CFG_W-1:0]           cfg_rdata,
    input logic [AW-1:0]              ptr_q,
    input logic [LW-1:0]              len_act
);

    a_r1_clear_taps_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (taps == '0 && fld_tap == '0));

    a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && shift_n) |=> ($stable(taps) && $stable(ptr_q)));

    a_r6_ptr_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (LW'(ptr_q) < len_act));

    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !shift_n && LW'(ptr_q) == len_act - LW'(1)) |=> (ptr_q == '0));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr |-> (cfg_rdata[CFG_W-1:4] == '0));

endmodule

bind line_delay_bank line_delay_bank_chk #(
    .PIX_W     (PIX_W),
    .NUM_LINES (NUM_LINES),
    .CFG_W     (CFG_W),
    .AW        (AW),
    .LW        (LW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_n   (shift_n),
    .ready     (ready),
    .taps      (taps),
    .fld_tap   (fld_tap),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .ptr_q     (ptr_q),
    .len_act   (len_act)
);

// File: tb/tb_line_delay_bank.sv
module tb_line_delay_bank;

    localparam int PW = 8;
    localparam int NL = 3;
    localparam int ML = 64;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          shift_n = 1'b1;
    logic [PW-1:0] pix_in = '0;
    logic [PW-1:0] fld_in = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] cfg_rdata;
    logic          ready;
    logic [NL*PW-1:0] taps;
    logic [PW-1:0] fld_tap;

    always #4 clk = ~clk;

    line_delay_bank dut (
        .clk(clk), .rst_n(rst_n), .shift_n(shift_n), .pix_in(pix_in),
        .fld_in(fld_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ready(ready),
        .taps(taps), .fld_tap(fld_tap)
    );

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit started = 0;

    // behavioural reference
    int m_mem [NL+1][ML];
    int m_tap [NL+1];
    int m_ptr, m_len_act, m_len_reg, m_mode, m_inq, m_fq, m_cnt;
    bit m_ready;

    function automatic int eff(int v);
        if (v == 0) return 1;
        if (v > ML) return ML;
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k <= NL; k++) begin
                m_tap[k] = 0;
                for (int a = 0; a < ML; a++) m_mem[k][a] = 0;
            end
            m_ptr = 0; m_len_act = 1; m_len_reg = 0; m_mode = 0;
            m_inq = 0; m_fq = 0; m_cnt = 0; m_ready = 0;
        end else begin
            int ol;
            int om;
            int pop [NL+1];
            ol = m_len_reg;
            om = m_mode;
            if (!m_ready) begin
                m_cnt++;
                if (m_cnt == ML) begin
                    m_ready = 1; m_ptr = 0; m_len_act = eff(ol);
                end
            end else if (!shift_n) begin
                for (int k = 0; k <= NL; k++) pop[k] = m_mem[k][m_ptr];
                for (int k = 0; k <= NL; k++) begin
                    int s;
                    if (om & 1) s = pop[k];
                    else if (k == NL) s = m_fq;
                    else if (k == 0 || (om & 2) != 0) s = m_inq;
                    else s = pop[k-1];
                    m_mem[k][m_ptr] = s;
                    m_tap[k] = pop[k];
                end
                m_inq = int'(pix_in);
                m_fq = (om & 4) ? int'(fld_in) : 0;
                if (m_ptr == m_len_act - 1) begin
                    m_ptr = 0; m_len_act = eff(ol);
                end else begin
                    m_ptr++;
                end
            end
            if (cfg_we) begin
                if (cfg_addr) m_mode = int'(cfg_wdata) & 15;
                else m_len_reg = int'(cfg_wdata);
            end
            started = 1;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1", "tap0 in reset", int'(taps[PW-1:0]), 0);
            chk("R1", "ready in reset", int'(ready), 0);
        end else if (started) begin
            for (int k = 0; k < NL; k++)
                chk(cur_req, $sformatf("tap%0d", k), int'(taps[k*PW +: PW]), m_tap[k]);
            chk(cur_req, "fld_tap", int'(fld_tap), (m_mode & 8) ? m_tap[NL] : 0);
            chk("R1", "ready", int'(ready), int'(m_ready));
            chk("R7", "cfg_rdata", int'(cfg_rdata), cfg_addr ? m_mode : m_len_reg);
        end
    end

    task automatic cyc(bit shn, int pix, int fld);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        shift_n = shn;
        pix_in = PW'(pix);
        fld_in = PW'(fld);
    endtask

    task automatic wr(bit a, int d);
        @(posedge clk); #1;
        shift_n = 1'b1;
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = CW'(d);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: shifts during the clearing pass are ignored
        cur_req = "R10";
        wr(0, 5);
        for (int i = 0; i < 80; i++) cyc(0, i * 3 + 1, i);
        // R2: cascade delay with some hold cycles
        cur_req = "R2";
        for (int i = 0; i < 60; i++) cyc(i % 4 == 3, i * 7 + 3, 0);
        // R5: hold while inputs change
        cur_req = "R5";
        for (int i = 0; i < 12; i++) cyc(1, i + 100, i);
        cyc(0, 9, 0);
        // R4: parallel loading
        wr(1, 2);
        cur_req = "R4";
        for (int i = 0; i < 40; i++) cyc(0, i * 11 + 5, 0);
        // R3: recirculation ignores new pixels
        wr(1, 1);
        cur_req = "R3";
        for (int i = 0; i < 40; i++) cyc(0, i * 13, 0);
        // R9: field port and buffer enabled
        wr(1, 12);
        cur_req = "R9";
        for (int i = 0; i < 40; i++) cyc(0, i * 5, 200 - i);
        // R8: field port off, buffer on: zeros flow in
        wr(1, 8);
        cur_req = "R8";
        for (int i = 0; i < 40; i++) cyc(0, i, 77);
        // R6: length 0, clamp above max, then 17, each deferred to a wrap
        wr(1, 0);
        cur_req = "R6";
        for (int i = 0; i < 3; i++) cyc(0, i + 40, 0);
        wr(0, 0);
        for (int i = 0; i < 30; i++) cyc(i % 5 == 2, i * 9, 0);
        wr(0, 100);
        for (int i = 0; i < 220; i++) cyc(i % 7 == 6, i * 3, 0);
        cyc(0, 1, 0);
        cyc(0, 2, 0);
        wr(0, 17);
        for (int i = 0; i < 90; i++) cyc(0, i * 5 + 2, 0);
        // R7: reserved mode bits and length read-back
        cur_req = "R7";
        wr(1, 12'hFFF);
        cyc(1, 0, 0);
        chk("R7", "mode readback", int'(cfg_rdata), 15);
        wr(0, 12'hABC);
        cyc(1, 0, 0);
        chk("R7", "length readback", int'(cfg_rdata), 12'hABC);
        repeat (3) cyc(1, 0, 0);
        finish_run();
    end

endmodule